// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block conditions a single external interrupt pin for a small microcontroller. The raw pin first passes through a synchronizer. A stability filter then accepts a new level only after the synchronized value has differed from the accepted level for a set number of consecutive system clocks. Each accepted level change is classified as rising or falling. The configuration decides whether the change counts as a valid edge: it selects either a single polarity (rising or falling) or both polarities.

A valid edge sets a request flag, gives one-cycle wakeup and timer-start pulses, and can be consumed in one of two ways. With interrupt routing on and the global interrupt enable set, the flag drives the interrupt request, and an acknowledge clears it. With routing off, a skip-test strobe from the core reads the flag, and a successful test clears it. If a new edge arrives in the same cycle as a clear, the new edge wins.

Top module: `xint_edge_unit`

## Requirements
- R1: While `pin_en` is 0, pin activity produces no wakeup pulse, no timer-start pulse and no flag set, and re-enabling does not report a stale edge.
- R2: With `both_edges`=1, every accepted level change (low to high and high to low) is a valid edge.
- R3: With `both_edges`=0, only one direction is valid: `rise_sel`=1 accepts low to high only, and `rise_sel`=0 accepts high to low only.
- R4: A new pin level is accepted only if it is held for at least 4 consecutive clocks; shorter pulses produce no edge. A level driven before clock edge E0 and held is accepted at edge E5, so the pulses are high after E5.
- R5: A valid edge sets the request flag at the following clock edge. After reset the flag is 0, and a pin held high through reset reports no edge.
- R6: `irq_ack` clears the flag at the next clock edge; if a valid edge occurs in that same cycle, the flag stays set.
- R7: `irq_req` is high exactly when the flag is set, `irq_route` is 1 and `glob_ie` is 1.
- R8: With `irq_route`=0, `skip_cond` shows the flag during a `skip_test` strobe, and a test that finds the flag set clears it at the next edge; with `irq_route`=1, `skip_cond` stays 0.
- R9: Each valid edge gives exactly one one-cycle pulse on `wake_pulse` and one on `tmr_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external interrupt pin |
| pin_en | input | 1 | Pin input enable |
| both_edges | input | 1 | 1: both edges, 0: one direction |
| rise_sel | input | 1 | In one-direction mode, 1: rising, 0: falling |
| irq_route | input | 1 | 1: flag drives interrupt, 0: flag is polled |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt accepted, clears the flag |
| skip_test | input | 1 | One-cycle skip-test strobe |
| skip_cond | output | 1 | Skip condition returned to the core |
| irq_req | output | 1 | Interrupt request |
| wake_pulse | output | 1 | Wakeup pulse per valid edge |
| tmr_start | output | 1 | Timer count-start pulse per valid edge |

## Verification
The assertions assume that `irq_ack` and `skip_test` are single-cycle strobes and that the configuration inputs are not changed while a level change is in the filter. The bench changes the configuration only under reset or between quiet intervals. It sweeps every mode, both idle levels and pulse widths from 1 to 6 clocks, and then runs directed sequences for disable, routing and a clear that coincides with a new edge.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef struct packed {
        logic both;   // 1: both directions valid
        logic rise;   // one-direction mode: 1 rising, 0 falling
    } edge_cfg_t;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } edge_dir_e;

    function automatic logic edge_accepts(edge_cfg_t cfg, edge_dir_e dir);
        return cfg.both | (cfg.rise == dir);
    endfunction

endpackage

// File: rtl/xint_sync_filter.sv
module xint_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic pin_en,
    output logic lvl,
    output logic chg
);
    localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt;
    logic                   s_pin;

    assign s_pin = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_STAGES{pin_raw}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= pin_raw;
            cnt <= '0;
            chg <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (!pin_en) begin
                lvl <= s_pin;
                cnt <= '0;
            end else if (s_pin == lvl) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                lvl <= s_pin;
                cnt <= '0;
                chg <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R1: nothing is reported while the pin is disabled
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !pin_en |=> !chg);

    // R4: a reported change always moves the accepted level
    assert_chg_moves_R4: assert property (@(posedge clk) disable iff (rst)
        chg |-> (lvl != $past(lvl)));

    // R4: no change is reported before the hold count is reached
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_en && s_pin != lvl && cnt != LAST) |=> !chg);

endmodule

// File: rtl/xint_edge_sel.sv
module xint_edge_sel
    import xint_pkg::*;
(
    input  edge_cfg_t cfg,
    input  logic      chg,
    input  logic      lvl,
    output logic      valid
);
    edge_dir_e dir;

    always_comb begin
        dir   = lvl ? DIR_RISE : DIR_FALL;
        valid = chg & edge_accepts(cfg, dir);
    end

endmodule

// File: rtl/xint_req_flag.sv
module xint_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic irq_ack,
    input  logic skip_test,
    input  logic irq_route,
    input  logic glob_ie,
    output logic irq_req,
    output logic skip_cond
);
    logic flag;
    logic clr;

    assign skip_cond = skip_test & flag & ~irq_route;
    assign irq_req   = flag & irq_route & glob_ie;
    assign clr       = irq_ack | skip_cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end

    // R5: a valid edge always leaves the flag set
    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R6: an acknowledge with no new edge empties the flag
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !set) |=> !flag);

    // R8: a successful skip test with no new edge empties the flag
    assert_skip_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (skip_cond && !set) |=> !skip_cond && !irq_req);

    // R8: polling never reports while interrupt routing is on
    assert_skip_route_R8: assert property (@(posedge clk) disable iff (rst)
        irq_route |-> !skip_cond);

endmodule

// File: rtl/xint_edge_unit.sv
module xint_edge_unit
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic pin_en,
    input  logic both_edges,
    input  logic rise_sel,
    input  logic irq_route,
    input  logic glob_ie,
    input  logic irq_ack,
    input  logic skip_test,
    output logic skip_cond,
    output logic irq_req,
    output logic wake_pulse,
    output logic tmr_start
);
    edge_cfg_t cfg;
    logic      lvl;
    logic      chg;
    logic      valid;

    assign cfg.both = both_edges;
    assign cfg.rise = rise_sel;

    xint_sync_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYCLES (FILT_CYCLES)
    ) filt_i (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .pin_en  (pin_en),
        .lvl     (lvl),
        .chg     (chg)
    );

    xint_edge_sel sel_i (
        .cfg   (cfg),
        .chg   (chg),
        .lvl   (lvl),
        .valid (valid)
    );

    xint_req_flag flag_i (
        .clk       (clk),
        .rst       (rst),
        .set       (valid),
        .irq_ack   (irq_ack),
        .skip_test (skip_test),
        .irq_route (irq_route),
        .glob_ie   (glob_ie),
        .irq_req   (irq_req),
        .skip_cond (skip_cond)
    );

    assign wake_pulse = valid;
    assign tmr_start  = valid;

    // R9: pulses are single-cycle
    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

endmodule

// File: tb/xint_edge_unit_tb_top.sv
module xint_edge_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_raw = 1'b0, pin_en = 1'b1, both_edges = 1'b0, rise_sel = 1'b0;
    logic irq_route = 1'b0, glob_ie = 1'b0, irq_ack = 1'b0, skip_test = 1'b0;
    logic skip_cond, irq_req, wake_pulse, tmr_start;

    int n_checks = 0;
    int n_fail   = 0;
    int wake_cnt = 0;
    int tmr_cnt  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    xint_edge_unit dut_i (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .pin_en(pin_en),
        .both_edges(both_edges), .rise_sel(rise_sel), .irq_route(irq_route),
        .glob_ie(glob_ie), .irq_ack(irq_ack), .skip_test(skip_test),
        .skip_cond(skip_cond), .irq_req(irq_req), .wake_pulse(wake_pulse),
        .tmr_start(tmr_start)
    );

    always @(negedge clk) begin
        if (!rst) begin
            wake_cnt += int'(wake_pulse);
            tmr_cnt  += int'(tmr_start);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk);
        #1;
        wake_cnt = 0;
        tmr_cnt  = 0;
    endtask

    task automatic do_reset(input logic base);
        @(negedge clk);
        rst = 1'b1; pin_raw = base; irq_ack = 1'b0; skip_test = 1'b0;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    function automatic int accepts(input logic both, input logic rise, input logic dir_rise);
        return (both || (rise == dir_rise)) ? 1 : 0;
    endfunction

    // Sweep one configuration / idle level / pulse width
    task automatic run_case(input logic both, input logic rise, input logic base, input int w);
        int exp_edges;
        both_edges = both; rise_sel = rise; pin_en = 1'b1;
        irq_route = 1'b0; glob_ie = 1'b0;
        do_reset(base);
        clear_counts();
        chk(wake_cnt == 0, "R5 no edge out of reset", wake_cnt, 0);
        @(negedge clk);
        pin_raw = ~base;
        cycles(w);
        pin_raw = base;
        cycles(14);
        exp_edges = (w >= 4) ? (accepts(both, rise, ~base) + accepts(both, rise, base)) : 0;
        chk(wake_cnt == exp_edges, "R2/R3/R4 wake count", wake_cnt, exp_edges);
        chk(tmr_cnt == exp_edges, "R9 timer-start count", tmr_cnt, exp_edges);
        skip_test = 1'b1;
        #1;
        chk(skip_cond == (exp_edges > 0), "R8 skip reads flag", int'(skip_cond), int'(exp_edges > 0));
        @(negedge clk);
        #1;
        chk(skip_cond == 1'b0, "R8 skip clears flag", int'(skip_cond), 0);
        skip_test = 1'b0;
    endtask

    initial begin
        // Reset state
        do_reset(1'b1);
        irq_route = 1'b1; glob_ie = 1'b1;
        #1;
        chk(irq_req == 1'b0, "R5 reset flag clear", int'(irq_req), 0);

        // Sweep modes, idle levels and pulse widths
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int w = 1; w <= 6; w++) begin
                    run_case(m[1], m[0], b[0], w);
                end
            end
        end

        // R4 latency: change before edge E0 gives a wake pulse after E5
        both_edges = 1'b1; irq_route = 1'b0;
        do_reset(1'b0);
        @(negedge clk);
        pin_raw = 1'b1;
        cycles(5);
        #1;
        chk(wake_pulse == 1'b0, "R4 no pulse before E5", int'(wake_pulse), 0);
        @(negedge clk);
        #1;
        chk(wake_pulse == 1'b1, "R4 pulse after E5", int'(wake_pulse), 1);
        cycles(4);

        // R1: disabled pin is ignored, no stale edge on re-enable
        both_edges = 1'b1; irq_route = 1'b0;
        do_reset(1'b0);
        pin_en = 1'b0;
        clear_counts();
        pin_raw = 1'b1;
        cycles(10);
        pin_en = 1'b1;
        cycles(10);
        chk(wake_cnt == 0, "R1 disabled pin ignored", wake_cnt, 0);
        skip_test = 1'b1;
        #1;
        chk(skip_cond == 1'b0, "R1 flag untouched", int'(skip_cond), 0);
        @(negedge clk);
        skip_test = 1'b0;

        // R7 / R8 / R6: interrupt routing
        both_edges = 1'b1; irq_route = 1'b1; glob_ie = 1'b0;
        do_reset(1'b0);
        pin_raw = 1'b1;
        cycles(10);
        #1;
        chk(irq_req == 1'b0, "R7 gated by global enable", int'(irq_req), 0);
        skip_test = 1'b1;
        #1;
        chk(skip_cond == 1'b0, "R8 no skip when routed", int'(skip_cond), 0);
        @(negedge clk);
        skip_test = 1'b0;
        glob_ie = 1'b1;
        #1;
        chk(irq_req == 1'b1, "R7 request raised", int'(irq_req), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk(irq_req == 1'b0, "R6 ack clears flag", int'(irq_req), 0);
        irq_route = 1'b0;
        #1;
        chk(irq_req == 1'b0, "R7 routing off", int'(irq_req), 0);

        // R6: new edge in the same cycle as an acknowledge keeps the flag
        irq_route = 1'b1;
        pin_raw = 1'b0;
        cycles(10);
        #1;
        chk(irq_req == 1'b1, "R6 flag set before race", int'(irq_req), 1);
        pin_raw = 1'b1;
        @(negedge clk);
        while (!wake_pulse) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk(irq_req == 1'b1, "R6 set wins over clear", int'(irq_req), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk(irq_req == 1'b0, "R6 second ack clears", int'(irq_req), 0);

        cycles(2);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule